// File: doc/BRIEF.md
# Audio Link Reset Controller

This block owns the reset line and the idle levels of a serial audio codec link while the system moves between reset and its sleep states. It keeps a small global control register that software writes and reads. One bit of that register is the codec release bit, which holds the link reset when it is zero. A second bit is the link shut-off bit, which turns on the pull-downs of the link pins.

The codec reset is sticky. A resume-well reset, a platform reset (mechanical power-up also produces one), a hard-reset request, a deep sleep state, or a software write of zero all pull it low. Only a software write of one lets it go high again, and that write is refused while the system is in a deep sleep state. The data-out and frame-sync lines run only in the working state outside platform reset. Everywhere else they are gated low.

Every output is registered on the always-powered resume clock domain. The outputs therefore keep being driven in every sleep state. The synchronous resume-well reset is the block's only reset input.

Top module: `alink_rst_ctrl`

## Requirements
- R1: While `rsm_rst` is high, a clock edge sets `codec_rst_n`, `sdo_run`, `sync_run` and `link_pd_en` to 0 and `cfg_rdata` to 0.
- R2: The release bit is bit 1 of the control register. A write (`cfg_we`=1) with bit 1 set, in S0 or S1 with no assertion source active, makes `codec_rst_n` 1 and readback bit 1 equal to 1 after the same clock edge. `codec_rst_n` never rises without such a write.
- R3: A write with bit 1 clear drives `codec_rst_n` to 0 and clears readback bit 1 after that edge.
- R4: A cycle with `plat_rst` or `hard_rst_req` high clears the release bit and drives `codec_rst_n` low. The line stays low in later idle cycles.
- R5: `slp_state` codes are 00=S0, 01=S1, 10=S3 and 11=S4/S5. In 10 or 11 the release bit is cleared and `codec_rst_n` is held low, and writes of 1 to bit 1 are ignored. After a return to S0 the line stays low until bit 1 is written again.
- R6: In S1 `codec_rst_n` follows the written value of bit 1.
- R7: When an assertion source and a write of 1 to bit 1 fall in the same cycle, the assertion wins and `codec_rst_n` is 0 after that edge.
- R8: `sdo_run` and `sync_run` are 1 one edge after a cycle in S0 with `plat_rst` low. They are 0 one edge after any other cycle.
- R9: The shut-off bit is bit 3 of the control register. `link_pd_en` equals that bit. The bit can be written in any sleep state and is cleared by `plat_rst`.
- R10: Every readback bit other than 1 and 3 reads 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resume-domain clock |
| rsm_rst | input | 1 | Resume-well reset, synchronous, active high |
| plat_rst | input | 1 | Platform reset, active high |
| hard_rst_req | input | 1 | Hard-reset request pulse |
| slp_state | input | 2 | Sleep state code (00 S0, 01 S1, 10 S3, 11 S4/S5) |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register readback |
| codec_rst_n | output | 1 | Codec reset, active low |
| sdo_run | output | 1 | 1 lets serial data-out run, 0 holds it low |
| sync_run | output | 1 | 1 lets frame sync run, 0 holds it low |
| link_pd_en | output | 1 | Pull-down enable for the link pins |

## Verification
A software write that sets the release bit and a hardware assertion source can arrive on the same clock edge. The bench provokes this by raising the write strobe with bit 1 set in the same cycle as a hard-reset request, a platform reset, or an S3 code. After each of those edges it expects the reset to be low and the readback bit to be clear. A reference model in the bench predicts every output cycle by cycle, so any resolution of the conflict other than "assertion wins" shows up as a mismatch on that edge.

// File: rtl/alink_pkg.sv
package alink_pkg;
  typedef enum logic [1:0] {
    SLP_S0  = 2'b00,
    SLP_S1  = 2'b01,
    SLP_S3  = 2'b10,
    SLP_S45 = 2'b11
  } slp_e;

  localparam int unsigned GCTL_W   = 32;
  localparam int unsigned COLD_POS = 1;
  localparam int unsigned SHUT_POS = 3;
endpackage

// File: rtl/alink_rst_src.sv
// Combines the hardware events that force the codec reset low.
module alink_rst_src
  import alink_pkg::*;
(
  input  logic       plat_rst,
  input  logic       hard_rst_req,
  input  logic [1:0] slp_state,
  output logic       force_assert,
  output logic       deep_sleep,
  output logic       link_idle
);
  slp_e st;
  assign st = slp_e'(slp_state);

  always_comb begin
    deep_sleep   = (st == SLP_S3) || (st == SLP_S45);
    force_assert = plat_rst || hard_rst_req || deep_sleep;
    link_idle    = plat_rst || (st != SLP_S0);
  end
endmodule

// File: rtl/alink_gctl_reg.sv
// Global control register: release bit and shut-off bit.
module alink_gctl_reg #(
  parameter int unsigned W    = 32,
  parameter int unsigned COLD = 1,
  parameter int unsigned SHUT = 3
) (
  input  logic         clk,
  input  logic         rsm_rst,
  input  logic         core_rst,
  input  logic         force_assert,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic         cold_nxt,
  output logic         shut_nxt,
  output logic [W-1:0] rdata
);
  logic cold_q, shut_q;
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  // Assertion sources override a release in the same cycle.
  always_comb begin
    cold_nxt = cold_q;
    if (we)           cold_nxt = wdata[COLD];
    if (force_assert) cold_nxt = 1'b0;
    if (rsm_rst)      cold_nxt = 1'b0;

    shut_nxt = shut_q;
    if (we)       shut_nxt = wdata[SHUT];
    if (core_rst) shut_nxt = 1'b0;
    if (rsm_rst)  shut_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    cold_q <= cold_nxt;
    shut_q <= shut_nxt;
  end

  for (genvar i = 0; i < W; i++) begin : g_rb
    if (i == COLD) begin : g_cold
      assign rdata[i] = cold_q;
    end else if (i == SHUT) begin : g_shut
      assign rdata[i] = shut_q;
    end else begin : g_zero
      assign rdata[i] = 1'b0;
    end
  end
endmodule

// File: rtl/alink_pin_stage.sv
// Registered link pin controls, held in the resume domain.
module alink_pin_stage (
  input  logic clk,
  input  logic rsm_rst,
  input  logic cold_nxt,
  input  logic shut_nxt,
  input  logic link_idle,
  output logic codec_rst_n,
  output logic sdo_run,
  output logic sync_run,
  output logic link_pd_en
);
  always_ff @(posedge clk) begin
    if (rsm_rst) begin
      codec_rst_n <= 1'b0;
      sdo_run     <= 1'b0;
      sync_run    <= 1'b0;
      link_pd_en  <= 1'b0;
    end else begin
      codec_rst_n <= cold_nxt;
      sdo_run     <= !link_idle;
      sync_run    <= !link_idle;
      link_pd_en  <= shut_nxt;
    end
  end
endmodule

// File: rtl/alink_rst_ctrl.sv
module alink_rst_ctrl
  import alink_pkg::*;
#(
  parameter int unsigned W    = GCTL_W,
  parameter int unsigned COLD = COLD_POS,
  parameter int unsigned SHUT = SHUT_POS
) (
  input  logic         clk,
  input  logic         rsm_rst,
  input  logic         plat_rst,
  input  logic         hard_rst_req,
  input  logic [1:0]   slp_state,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  output logic         codec_rst_n,
  output logic         sdo_run,
  output logic         sync_run,
  output logic         link_pd_en
);
  logic force_assert, deep_sleep, link_idle, cold_nxt, shut_nxt;
  logic unused_deep;
  assign unused_deep = deep_sleep;

  alink_rst_src u_src (
    .plat_rst(plat_rst), .hard_rst_req(hard_rst_req), .slp_state(slp_state),
    .force_assert(force_assert), .deep_sleep(deep_sleep), .link_idle(link_idle)
  );

  alink_gctl_reg #(.W(W), .COLD(COLD), .SHUT(SHUT)) u_reg (
    .clk(clk), .rsm_rst(rsm_rst), .core_rst(plat_rst), .force_assert(force_assert),
    .we(cfg_we), .wdata(cfg_wdata), .cold_nxt(cold_nxt), .shut_nxt(shut_nxt),
    .rdata(cfg_rdata)
  );

  alink_pin_stage u_pins (
    .clk(clk), .rsm_rst(rsm_rst), .cold_nxt(cold_nxt), .shut_nxt(shut_nxt),
    .link_idle(link_idle), .codec_rst_n(codec_rst_n), .sdo_run(sdo_run),
    .sync_run(sync_run), .link_pd_en(link_pd_en)
  );
endmodule

// File: rtl/alink_rst_ctrl_chk.sv
module alink_rst_ctrl_chk #(
  parameter int unsigned W    = 32,
  parameter int unsigned COLD = 1,
  parameter int unsigned SHUT = 3
) (
  input logic         clk,
  input logic         rsm_rst,
  input logic         plat_rst,
  input logic         hard_rst_req,
  input logic [1:0]   slp_state,
  input logic         cfg_we,
  input logic [W-1:0] cfg_wdata,
  input logic [W-1:0] cfg_rdata,
  input logic         codec_rst_n,
  input logic         sdo_run,
  input logic         sync_run,
  input logic         link_pd_en
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  localparam logic [W-1:0] KEEP = (W'(1) << COLD) | (W'(1) << SHUT);

  AST_RESET_STATE: assert property (@(posedge clk)
    past_ok && $past(rsm_rst) |-> !codec_rst_n && !sdo_run && !sync_run && !link_pd_en && cfg_rdata == '0); // R1
  AST_NO_HW_RELEASE: assert property (@(posedge clk) disable iff (rsm_rst)
    $rose(codec_rst_n) |-> $past(cfg_we && cfg_wdata[COLD])); // R2
  AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (rsm_rst)
    $past(slp_state[1]) |-> !codec_rst_n && !cfg_rdata[COLD]); // R5
  AST_SRC_WINS: assert property (@(posedge clk) disable iff (rsm_rst)
    $past(plat_rst || hard_rst_req) |-> !codec_rst_n && !cfg_rdata[COLD]); // R7
  AST_RUN_GATE: assert property (@(posedge clk) disable iff (rsm_rst)
    $past(slp_state != 2'b00 || plat_rst) |-> !sdo_run && !sync_run); // R8
  AST_PD_FOLLOW: assert property (@(posedge clk) disable iff (rsm_rst)
    link_pd_en == cfg_rdata[SHUT]); // R9
  AST_RB_ZERO: assert property (@(posedge clk) disable iff (rsm_rst)
    (cfg_rdata & ~KEEP) == '0); // R10
endmodule

bind alink_rst_ctrl alink_rst_ctrl_chk #(.W(W), .COLD(COLD), .SHUT(SHUT)) u_chk (.*);

// File: tb/alink_rst_ctrl_tb.sv
module alink_rst_ctrl_tb;
  logic        clk = 1'b0;
  logic        rsm_rst = 1'b1, plat_rst = 1'b0, hard_rst_req = 1'b0, cfg_we = 1'b0;
  logic [1:0]  slp_state = 2'b00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        codec_rst_n, sdo_run, sync_run, link_pd_en;

  int n_chk = 0, n_fail = 0;
  int m_cold = 0, m_shut = 0, m_run = 0;

  always #2 clk = ~clk;

  alink_rst_ctrl u_dut (
    .clk(clk), .rsm_rst(rsm_rst), .plat_rst(plat_rst), .hard_rst_req(hard_rst_req),
    .slp_state(slp_state), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .codec_rst_n(codec_rst_n), .sdo_run(sdo_run), .sync_run(sync_run), .link_pd_en(link_pd_en)
  );

  task automatic check(string what, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model the edge, compare shortly after it.
  task automatic cyc(string tag, logic rs, logic pr, logic hr, logic [1:0] sl,
                     logic we, logic [31:0] wd);
    @(negedge clk);
    rsm_rst = rs; plat_rst = pr; hard_rst_req = hr; slp_state = sl;
    cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    if (rs) begin
      m_cold = 0; m_shut = 0; m_run = 0;
    end else begin
      if (we) begin
        m_cold = int'(wd[1]);
        m_shut = int'(wd[3]);
      end
      if (pr || hr || sl >= 2'd2) m_cold = 0;
      if (pr) m_shut = 0;
      m_run = (sl == 2'd0 && !pr) ? 1 : 0;
    end
    #1;
    check("codec_rst_n", tag, 32'(codec_rst_n), 32'(m_cold));
    check("sdo_run",     tag, 32'(sdo_run),     32'(m_run));
    check("sync_run",    tag, 32'(sync_run),    32'(m_run));
    check("link_pd_en",  tag, 32'(link_pd_en),  32'(m_shut));
    check("cfg_rdata",   tag, cfg_rdata,        32'((m_cold << 1) | (m_shut << 3)));
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) cyc("R1", 1, 0, 0, 2'd0, 1, 32'hFFFF_FFFF);
    cyc("R8", 0, 0, 0, 2'd0, 0, 0);
    cyc("R8", 0, 0, 0, 2'd0, 0, 0);
    cyc("R2", 0, 0, 0, 2'd0, 1, 32'h2);
    cyc("R2", 0, 0, 0, 2'd0, 0, 0);
    cyc("R10", 0, 0, 0, 2'd0, 1, 32'hFFFF_FFFF);
    cyc("R9", 0, 0, 0, 2'd0, 1, 32'h2);
    cyc("R3", 0, 0, 0, 2'd0, 1, 32'h0);
    cyc("R2", 0, 0, 0, 2'd0, 1, 32'hA);
    cyc("R4", 0, 1, 0, 2'd0, 0, 0);
    cyc("R4", 0, 0, 0, 2'd0, 0, 0);
    cyc("R4", 0, 0, 0, 2'd0, 0, 0);
    cyc("R2", 0, 0, 0, 2'd0, 1, 32'h2);
    cyc("R4", 0, 0, 1, 2'd0, 0, 0);
    cyc("R4", 0, 0, 0, 2'd0, 0, 0);
    cyc("R7", 0, 0, 1, 2'd0, 1, 32'hA);
    cyc("R7", 0, 1, 0, 2'd0, 1, 32'hA);
    cyc("R7", 0, 0, 0, 2'd2, 1, 32'h2);
    cyc("R6", 0, 0, 0, 2'd1, 1, 32'h2);
    cyc("R6", 0, 0, 0, 2'd1, 0, 0);
    cyc("R6", 0, 0, 0, 2'd1, 1, 32'h0);
    cyc("R6", 0, 0, 0, 2'd1, 1, 32'h2);
    cyc("R5", 0, 0, 0, 2'd2, 0, 0);
    cyc("R5", 0, 0, 0, 2'd2, 1, 32'h2);
    cyc("R9", 0, 0, 0, 2'd2, 1, 32'hA);
    cyc("R5", 0, 0, 0, 2'd3, 1, 32'hA);
    cyc("R5", 0, 0, 0, 2'd3, 0, 0);
    cyc("R5", 0, 0, 0, 2'd0, 0, 0);
    cyc("R5", 0, 0, 0, 2'd0, 0, 0);
    cyc("R5", 0, 0, 0, 2'd0, 1, 32'h2);
    cyc("R8", 0, 1, 0, 2'd0, 0, 0);
    cyc("R8", 0, 0, 0, 2'd0, 1, 32'hA);
    cyc("R10", 0, 0, 0, 2'd0, 1, 32'h5555_5555);
    cyc("R1", 1, 0, 0, 2'd0, 0, 0);
    cyc("R1", 0, 0, 0, 2'd0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule